// File: doc/BRIEF.md
# Converter Control Register Interface

This block is the host-side control register bank for a decimating converter. A host writes into it over a 16-bit word channel. Each access takes two words: the first names a register and the second carries the 16-bit value. The bank holds these registers:

- two control registers
- a gain register
- an offset register
- an overrange threshold register
- a read-only status register

From these registers it drives the configuration lines of the filter chain and of the analog front end. It also emits a one-cycle synchronisation pulse.

Reads are served from a one-shot read selector. A write to control register 1 may name one of the gain, offset, overrange or status registers. The next host read then returns that register, and every other read returns the conversion result presented on `conv_data`.

A download bit in control register 1 switches the write channel into a coefficient stream for the programmable FIR. The filter length field is written together with that bit. The stream carries a fixed number of coefficient words followed by one checksum word. A matching checksum commits the new coefficient set. A mismatch is flagged in the status register and leaves the filter that was loaded before in use.

Top module: `cvc_top`

## Requirements
- R1: Writes are word pairs: address word, then data word. Address 1 is control register 1, 2 is control register 2, 3 is gain, 4 is offset and 5 is the overrange threshold. A data word to any other address changes no output and no register. Registered values appear on the outputs one cycle after the data word is accepted.
- R2: After reset, control register 1 holds 0x001A, so decimation code 2 with both filters enabled and a filter length of 0. Control register 2 holds 0x009B, so divide-by-2 clocking, power-down set, low-power clear and amplifier power-down set. Gain resets to 0x4000, offset to 0x0000 and overrange to 0x7FFF.
- R3: In control register 1, bits 2:0 are the decimation code and bits 8:5 are the filter length. Bit 3 is the filter 1 enable and bit 4 the filter 3 enable, where 0 bypasses the filter. These outputs change only when a write word is accepted.
- R4: Decimation codes 0 to 5 are applied as written. A write of code 6 or 7 keeps the previous code and sets status bit 1.
- R5: In control register 1, bit 14 selects overrange, bit 13 gain, bit 12 offset and bit 11 status. A single set bit makes only the next read return that register. All other reads return `conv_data`.
- R6: A write with more than one of bits 14:11 set sets status bit 0, and the next read returns `conv_data`.
- R7: Bit 9 of control register 1 produces exactly one cycle of `sync_pulse`. Bits 15:9 are never held, so a later write without them produces no pulse and no read selection.
- R8: In control register 2, bit 5 set gives divide-by-1 clocking and clear gives divide-by-2. Bit 3 is power-down, bit 2 is low-power and bit 0 is amplifier power-down.
- R9: A control register 1 write with bit 15 set starts a download. The next (length+1)*8 accepted words are output as coefficients with indices counting up from 0. The word after them is taken as the checksum, and the channel then returns to address words. `dl_busy` is high for the whole download.
- R10: The checksum is the 16-bit wrapping sum of the coefficients. On a match, `coef_commit` pulses for one cycle and status bit 3 becomes 1. On a mismatch there is no commit, status bit 2 is set, and status bit 3 keeps its value.
- R11: Status bits 0, 1 and 2 are sticky error flags that a status read clears. Bit 3 shows that a downloaded filter is active. All other status bits read 0.
- R12: A read request is answered with `rd_valid` and `rd_data` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write word strobe |
| wr_word | input | 16 | Address, data, coefficient or checksum word |
| rd_req | input | 1 | Host read request |
| conv_data | input | 16 | Conversion result returned on default reads |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| dec_code | output | 3 | Filter 2 decimation code |
| filt1_en | output | 1 | Filter 1 enable |
| filt3_en | output | 1 | Filter 3 enable |
| filt_len | output | 4 | Filter length field |
| clk_div1 | output | 1 | 1 = divide by 1, 0 = divide by 2 |
| pwr_down | output | 1 | Converter power-down |
| low_pwr | output | 1 | Low-power mode |
| amp_pwr_down | output | 1 | Differential amplifier power-down |
| sync_pulse | output | 1 | One-cycle synchronisation pulse |
| gain_val | output | 16 | Gain register |
| offset_val | output | 16 | Offset register |
| ovr_thresh | output | 16 | Overrange threshold register |
| dl_busy | output | 1 | Coefficient download in progress |
| coef_we | output | 1 | Coefficient write strobe |
| coef_addr | output | 8 | Coefficient index |
| coef_data | output | 16 | Coefficient value |
| coef_commit | output | 1 | Checksum matched, new set active |

## Verification
The properties assume that the host keeps `wr_valid` low whenever it wants the configuration outputs to hold. They also assume that reset lasts at least one clock, so the word pairing starts from an address word. The stimulus always sends complete address/data pairs. During a download it sends exactly the announced number of coefficients and then one checksum, so no word is ever left without a meaning. It never issues a read in the same cycle as a write to control register 1, which keeps each read selector change separate from the read it affects.

// File: rtl/cvc_pkg.sv
package cvc_pkg;

    localparam int WORD_W = 16;

    localparam logic [WORD_W-1:0] ADDR_CTRL1  = 16'h0001;
    localparam logic [WORD_W-1:0] ADDR_CTRL2  = 16'h0002;
    localparam logic [WORD_W-1:0] ADDR_GAIN   = 16'h0003;
    localparam logic [WORD_W-1:0] ADDR_OFFSET = 16'h0004;
    localparam logic [WORD_W-1:0] ADDR_OVR    = 16'h0005;

    localparam logic [WORD_W-1:0] CTRL1_RST  = 16'h001A;
    localparam logic [WORD_W-1:0] CTRL2_RST  = 16'h009B;
    localparam logic [WORD_W-1:0] GAIN_RST   = 16'h4000;
    localparam logic [WORD_W-1:0] OFFSET_RST = 16'h0000;
    localparam logic [WORD_W-1:0] OVR_RST    = 16'h7FFF;

    localparam logic [2:0] DEC_MAX = 3'd5;

    typedef enum logic [2:0] {
        SRC_CONV, SRC_OVR, SRC_GAIN, SRC_OFF, SRC_STAT
    } rd_src_e;

    typedef enum logic [1:0] {
        PH_ADDR, PH_DATA, PH_COEF
    } wr_phase_e;

    typedef struct packed {
        logic       dl;
        logic [3:0] rsel;
        logic       rsvd;
        logic       sync;
        logic [3:0] flen;
        logic       f3_en;
        logic       f1_en;
        logic [2:0] dec;
    } ctrl1_t;

    typedef struct packed {
        logic [9:0] rsvd_hi;
        logic       cdiv;
        logic       rsvd4;
        logic       pd;
        logic       lpwr;
        logic       one;
        logic       amp_pd;
    } ctrl2_t;

    function automatic rd_src_e rsel_decode(input logic [3:0] r);
        case (r)
            4'b1000: return SRC_OVR;
            4'b0100: return SRC_GAIN;
            4'b0010: return SRC_OFF;
            4'b0001: return SRC_STAT;
            default: return SRC_CONV;
        endcase
    endfunction

    function automatic logic rsel_multi(input logic [3:0] r);
        return (r & (r - 4'd1)) != 4'd0;
    endfunction

endpackage

// File: rtl/cvc_wr_seq.sv
module cvc_wr_seq
    import cvc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              last_coef,
    output logic              reg_we,
    output logic [WORD_W-1:0] reg_addr,
    output logic              coef_beat,
    output logic              dl_start,
    output logic              dl_active
);
    wr_phase_e         phase_q;
    logic [WORD_W-1:0] addr_q;

    assign reg_we    = wr_valid && (phase_q == PH_DATA);
    assign coef_beat = wr_valid && (phase_q == PH_COEF);
    assign reg_addr  = addr_q;
    assign dl_start  = reg_we && (addr_q == ADDR_CTRL1) && wr_word[WORD_W-1];
    assign dl_active = (phase_q == PH_COEF);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ADDR;
            addr_q  <= '0;
        end else if (wr_valid) begin
            case (phase_q)
                PH_ADDR: begin
                    addr_q  <= wr_word;
                    phase_q <= PH_DATA;
                end
                PH_DATA: phase_q <= dl_start ? PH_COEF : PH_ADDR;
                PH_COEF: if (last_coef) phase_q <= PH_ADDR;
                default: phase_q <= PH_ADDR;
            endcase
        end
    end
endmodule

// File: rtl/cvc_dload.sv
module cvc_dload
    import cvc_pkg::*;
#(
    parameter int LEN_W     = 4,
    parameter int COEF_STEP = 8,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dl_start,
    input  logic [LEN_W-1:0]  flen,
    input  logic              coef_beat,
    input  logic [WORD_W-1:0] word,
    output logic              last_coef,
    output logic              coef_we,
    output logic [CNT_W-1:0]  coef_addr,
    output logic [WORD_W-1:0] coef_data,
    output logic              commit,
    output logic              csum_bad
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  idx_q;
    logic [WORD_W-1:0] sum_q;

    assign last_coef = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            sum_q     <= '0;
            coef_we   <= 1'b0;
            coef_addr <= '0;
            coef_data <= '0;
            commit    <= 1'b0;
            csum_bad  <= 1'b0;
        end else begin
            coef_we  <= 1'b0;
            commit   <= 1'b0;
            csum_bad <= 1'b0;
            if (dl_start) begin
                cnt_q <= CNT_W'((int'(flen) + 1) * COEF_STEP);
                idx_q <= '0;
                sum_q <= '0;
            end else if (coef_beat) begin
                if (!last_coef) begin
                    coef_we   <= 1'b1;
                    coef_addr <= idx_q;
                    coef_data <= word;
                    idx_q     <= idx_q + 1'b1;
                    sum_q     <= sum_q + word;
                    cnt_q     <= cnt_q - 1'b1;
                end else if (word == sum_q) begin
                    commit <= 1'b1;
                end else begin
                    csum_bad <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cvc_regfile.sv
module cvc_regfile
    import cvc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [WORD_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_data,
    input  logic              rd_req,
    input  logic              commit,
    input  logic              csum_bad,
    output logic [2:0]        dec_code,
    output logic              filt1_en,
    output logic              filt3_en,
    output logic [3:0]        filt_len,
    output logic              clk_div1,
    output logic              pwr_down,
    output logic              low_pwr,
    output logic              amp_pwr_down,
    output logic              sync_pulse,
    output logic [WORD_W-1:0] gain_val,
    output logic [WORD_W-1:0] offset_val,
    output logic [WORD_W-1:0] ovr_thresh,
    output rd_src_e           rd_src,
    output logic [WORD_W-1:0] status_word
);
    ctrl1_t            c1_in;
    ctrl2_t            c2_cur;
    logic [WORD_W-1:0] ctrl2_q;
    logic              sel_err_q, dec_err_q, csum_err_q, user_q;
    logic              wr_c1;
    logic              unused_bits;

    assign c1_in       = ctrl1_t'(reg_data);
    assign c2_cur      = ctrl2_t'(ctrl2_q);
    assign wr_c1       = reg_we && (reg_addr == ADDR_CTRL1);
    assign unused_bits = ^{c1_in.dl, c1_in.rsvd, c2_cur.rsvd_hi, c2_cur.rsvd4, c2_cur.one};

    assign clk_div1     = c2_cur.cdiv;
    assign pwr_down     = c2_cur.pd;
    assign low_pwr      = c2_cur.lpwr;
    assign amp_pwr_down = c2_cur.amp_pd;
    assign status_word  = {{(WORD_W-4){1'b0}}, user_q, csum_err_q, dec_err_q, sel_err_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_code   <= CTRL1_RST[2:0];
            filt1_en   <= CTRL1_RST[3];
            filt3_en   <= CTRL1_RST[4];
            filt_len   <= CTRL1_RST[8:5];
            ctrl2_q    <= CTRL2_RST;
            gain_val   <= GAIN_RST;
            offset_val <= OFFSET_RST;
            ovr_thresh <= OVR_RST;
            rd_src     <= SRC_CONV;
            sel_err_q  <= 1'b0;
            dec_err_q  <= 1'b0;
            csum_err_q <= 1'b0;
            user_q     <= 1'b0;
            sync_pulse <= 1'b0;
        end else begin
            sync_pulse <= 1'b0;
            if (rd_req) begin
                rd_src <= SRC_CONV;
                if (rd_src == SRC_STAT) begin
                    sel_err_q  <= 1'b0;
                    dec_err_q  <= 1'b0;
                    csum_err_q <= 1'b0;
                end
            end
            if (commit)   user_q     <= 1'b1;
            if (csum_bad) csum_err_q <= 1'b1;
            if (wr_c1) begin
                filt_len   <= c1_in.flen;
                filt3_en   <= c1_in.f3_en;
                filt1_en   <= c1_in.f1_en;
                sync_pulse <= c1_in.sync;
                rd_src     <= rsel_decode(c1_in.rsel);
                if (rsel_multi(c1_in.rsel)) sel_err_q <= 1'b1;
                if (c1_in.dec <= DEC_MAX) dec_code  <= c1_in.dec;
                else                      dec_err_q <= 1'b1;
            end
            if (reg_we && reg_addr == ADDR_CTRL2)  ctrl2_q    <= reg_data;
            if (reg_we && reg_addr == ADDR_GAIN)   gain_val   <= reg_data;
            if (reg_we && reg_addr == ADDR_OFFSET) offset_val <= reg_data;
            if (reg_we && reg_addr == ADDR_OVR)    ovr_thresh <= reg_data;
        end
    end
endmodule

// File: rtl/cvc_rdmux.sv
module cvc_rdmux
    import cvc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  rd_src_e           rd_src,
    input  logic [WORD_W-1:0] conv_data,
    input  logic [WORD_W-1:0] gain_val,
    input  logic [WORD_W-1:0] offset_val,
    input  logic [WORD_W-1:0] ovr_thresh,
    input  logic [WORD_W-1:0] status_word,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] sel_d;

    always_comb begin
        case (rd_src)
            SRC_OVR:  sel_d = ovr_thresh;
            SRC_GAIN: sel_d = gain_val;
            SRC_OFF:  sel_d = offset_val;
            SRC_STAT: sel_d = status_word;
            default:  sel_d = conv_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= sel_d;
        end
    end
endmodule

// File: rtl/cvc_top.sv
module cvc_top
    import cvc_pkg::*;
#(
    parameter int LEN_W     = 4,
    parameter int COEF_STEP = 8,
    localparam int CNT_W    = $clog2(((1 << LEN_W) * COEF_STEP) + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [15:0]       wr_word,
    input  logic              rd_req,
    input  logic [15:0]       conv_data,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic [2:0]        dec_code,
    output logic              filt1_en,
    output logic              filt3_en,
    output logic [3:0]        filt_len,
    output logic              clk_div1,
    output logic              pwr_down,
    output logic              low_pwr,
    output logic              amp_pwr_down,
    output logic              sync_pulse,
    output logic [15:0]       gain_val,
    output logic [15:0]       offset_val,
    output logic [15:0]       ovr_thresh,
    output logic              dl_busy,
    output logic              coef_we,
    output logic [CNT_W-1:0]  coef_addr,
    output logic [15:0]       coef_data,
    output logic              coef_commit
);
    logic              reg_we, coef_beat, dl_start, last_coef, csum_bad;
    logic [WORD_W-1:0] reg_addr, status_word;
    rd_src_e           rd_src;

    cvc_wr_seq u_seq (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_word(wr_word),
        .last_coef(last_coef), .reg_we(reg_we), .reg_addr(reg_addr),
        .coef_beat(coef_beat), .dl_start(dl_start), .dl_active(dl_busy)
    );

    cvc_dload #(.LEN_W(LEN_W), .COEF_STEP(COEF_STEP), .CNT_W(CNT_W)) u_dload (
        .clk(clk), .rst(rst), .dl_start(dl_start), .flen(wr_word[5 +: LEN_W]),
        .coef_beat(coef_beat), .word(wr_word), .last_coef(last_coef),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .commit(coef_commit), .csum_bad(csum_bad)
    );

    cvc_regfile u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_data(wr_word), .rd_req(rd_req), .commit(coef_commit),
        .csum_bad(csum_bad), .dec_code(dec_code), .filt1_en(filt1_en),
        .filt3_en(filt3_en), .filt_len(filt_len), .clk_div1(clk_div1),
        .pwr_down(pwr_down), .low_pwr(low_pwr), .amp_pwr_down(amp_pwr_down),
        .sync_pulse(sync_pulse), .gain_val(gain_val), .offset_val(offset_val),
        .ovr_thresh(ovr_thresh), .rd_src(rd_src), .status_word(status_word)
    );

    cvc_rdmux u_rd (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_src(rd_src),
        .conv_data(conv_data), .gain_val(gain_val), .offset_val(offset_val),
        .ovr_thresh(ovr_thresh), .status_word(status_word),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );
endmodule

// File: rtl/cvc_checker.sv
module cvc_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_valid,
    input logic       rd_req,
    input logic       rd_valid,
    input logic [2:0] dec_code,
    input logic       filt1_en,
    input logic       filt3_en,
    input logic [3:0] filt_len,
    input logic       sync_pulse,
    input logic       dl_busy,
    input logic       coef_we,
    input logic       coef_commit
);
    a_r7_sync_one_cycle: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> !sync_pulse);

    a_r10_commit_one_cycle: assert property (@(posedge clk) disable iff (rst)
        coef_commit |=> !coef_commit);

    a_r10_commit_after_word: assert property (@(posedge clk) disable iff (rst)
        coef_commit |-> $past(wr_valid));

    a_r4_dec_in_range: assert property (@(posedge clk) disable iff (rst)
        dec_code <= 3'd5);

    a_r3_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> $stable({dec_code, filt1_en, filt3_en, filt_len}));

    a_r9_coef_in_download: assert property (@(posedge clk) disable iff (rst)
        coef_we |-> $past(dl_busy));

    a_r12_read_latency: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);
endmodule

bind cvc_top cvc_checker chk_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .rd_req(rd_req),
    .rd_valid(rd_valid), .dec_code(dec_code), .filt1_en(filt1_en),
    .filt3_en(filt3_en), .filt_len(filt_len), .sync_pulse(sync_pulse),
    .dl_busy(dl_busy), .coef_we(coef_we), .coef_commit(coef_commit)
);

// File: tb/cvc_top_tb_top.sv
module cvc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_word = '0;
    logic        rd_req = 1'b0;
    logic [15:0] conv_data = 16'hC0DE;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [2:0]  dec_code;
    logic        filt1_en, filt3_en, clk_div1, pwr_down, low_pwr, amp_pwr_down;
    logic [3:0]  filt_len;
    logic        sync_pulse, dl_busy, coef_we, coef_commit;
    logic [15:0] gain_val, offset_val, ovr_thresh, coef_data;
    logic [7:0]  coef_addr;

    int checks = 0;
    int fails = 0;
    int coef_seen = 0;
    bit done = 0;

    logic [15:0] exp_rd_q[$];
    string       exp_rd_tag[$];
    logic [23:0] exp_coef_q[$];

    always #2 clk = ~clk;

    cvc_top dut_i (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_word(wr_word),
        .rd_req(rd_req), .conv_data(conv_data), .rd_valid(rd_valid),
        .rd_data(rd_data), .dec_code(dec_code), .filt1_en(filt1_en),
        .filt3_en(filt3_en), .filt_len(filt_len), .clk_div1(clk_div1),
        .pwr_down(pwr_down), .low_pwr(low_pwr), .amp_pwr_down(amp_pwr_down),
        .sync_pulse(sync_pulse), .gain_val(gain_val), .offset_val(offset_val),
        .ovr_thresh(ovr_thresh), .dl_busy(dl_busy), .coef_we(coef_we),
        .coef_addr(coef_addr), .coef_data(coef_data), .coef_commit(coef_commit)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic beat(input logic [15:0] w);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_word  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic write_reg(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_word  = a;
        @(negedge clk);
        wr_word  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] e, input string tag);
        @(negedge clk);
        rd_req = 1'b1;
        exp_rd_q.push_back(e);
        exp_rd_tag.push_back(tag);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    // Monitor: read results and coefficient writes against the scoreboard
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_rd_q.size() == 0) begin
                chk(1'b0, "R12 unexpected read", {16'h0, rd_data}, 32'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_rd_q.pop_front();
                t = exp_rd_tag.pop_front();
                chk(rd_data == e, t, {16'h0, rd_data}, {16'h0, e});
            end
        end
        if (!rst && coef_we) begin
            coef_seen++;
            if (exp_coef_q.size() == 0) begin
                chk(1'b0, "R9 unexpected coefficient", {8'h0, coef_addr, coef_data}, 32'h0);
            end else begin
                logic [23:0] e;
                e = exp_coef_q.pop_front();
                chk({coef_addr, coef_data} == e, "R9 coefficient", {8'h0, coef_addr, coef_data}, {8'h0, e});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] sum;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        chk({dec_code, filt1_en, filt3_en, filt_len} == {3'd2, 1'b1, 1'b1, 4'd0}, "R2 ctrl1 reset",
            {23'h0, dec_code, filt1_en, filt3_en, filt_len}, {23'h0, 3'd2, 1'b1, 1'b1, 4'd0});
        chk({clk_div1, pwr_down, low_pwr, amp_pwr_down} == 4'b0101, "R2 ctrl2 reset",
            {28'h0, clk_div1, pwr_down, low_pwr, amp_pwr_down}, 32'h5);
        chk({gain_val, offset_val} == {16'h4000, 16'h0000} && ovr_thresh == 16'h7FFF, "R2 data regs reset",
            {gain_val, ovr_thresh}, {16'h4000, 16'h7FFF});
        chk(!sync_pulse && !dl_busy && !coef_we && !coef_commit, "R2 strobes idle",
            {28'h0, sync_pulse, dl_busy, coef_we, coef_commit}, 32'h0);
        do_read(16'hC0DE, "R5 default read conversion");

        // R3 field decode
        write_reg(16'h0001, 16'h000D);
        chk({dec_code, filt1_en, filt3_en} == {3'd5, 1'b1, 1'b0}, "R3 dec/bypass decode",
            {27'h0, dec_code, filt1_en, filt3_en}, {27'h0, 3'd5, 1'b1, 1'b0});
        write_reg(16'h0001, 16'h0069);
        chk({dec_code, filt_len, filt1_en} == {3'd1, 4'd3, 1'b1}, "R3 length field",
            {24'h0, dec_code, filt_len, filt1_en}, {24'h0, 3'd1, 4'd3, 1'b1});
        write_reg(16'h0001, 16'h000D);

        // R4 invalid decimation code
        write_reg(16'h0001, 16'h000F);
        chk(dec_code == 3'd5, "R4 code 7 keeps previous", {29'h0, dec_code}, 32'd5);

        // R1 data registers and ignored addresses
        write_reg(16'h0003, 16'h1234);
        write_reg(16'h0004, 16'hFFEE);
        write_reg(16'h0005, 16'h0F0F);
        chk({gain_val, offset_val} == {16'h1234, 16'hFFEE} && ovr_thresh == 16'h0F0F, "R1 data regs written",
            {gain_val, offset_val}, {16'h1234, 16'hFFEE});
        write_reg(16'h0007, 16'hAAAA);
        write_reg(16'h0000, 16'h5555);
        chk({gain_val, offset_val} == {16'h1234, 16'hFFEE} && ovr_thresh == 16'h0F0F && dec_code == 3'd5
            && pwr_down && !clk_div1, "R1 unknown address ignored", {gain_val, offset_val}, {16'h1234, 16'hFFEE});

        // R5 one-shot read selection
        write_reg(16'h0001, 16'h200D);
        do_read(16'h1234, "R5 gain read");
        do_read(16'hC0DE, "R5 one-shot back to conversion");
        write_reg(16'h0001, 16'h400D);
        do_read(16'h0F0F, "R5 overrange read");
        write_reg(16'h0001, 16'h100D);
        do_read(16'hFFEE, "R5 offset read");

        // R11 status and sticky clear
        write_reg(16'h0001, 16'h080D);
        do_read(16'h0002, "R11 status shows dec error");
        write_reg(16'h0001, 16'h080D);
        do_read(16'h0000, "R11 status cleared by read");

        // R6 multiple selection
        write_reg(16'h0001, 16'h600D);
        do_read(16'hC0DE, "R6 multi-select reads conversion");
        write_reg(16'h0001, 16'h080D);
        do_read(16'h0001, "R6 multi-select error flag");

        // R7 sync pulse, self-clearing
        write_reg(16'h0001, 16'h020D);
        chk(sync_pulse == 1'b1, "R7 sync pulse high", {31'h0, sync_pulse}, 32'h1);
        @(negedge clk);
        chk(sync_pulse == 1'b0, "R7 sync pulse one cycle", {31'h0, sync_pulse}, 32'h0);
        write_reg(16'h0001, 16'h000D);
        chk(sync_pulse == 1'b0, "R7 sync not held", {31'h0, sync_pulse}, 32'h0);
        do_read(16'hC0DE, "R7 selection not held");

        // R8 control register 2
        write_reg(16'h0002, 16'h0022);
        chk({clk_div1, pwr_down, low_pwr, amp_pwr_down} == 4'b1000, "R8 ctrl2 decode A",
            {28'h0, clk_div1, pwr_down, low_pwr, amp_pwr_down}, 32'h8);
        write_reg(16'h0002, 16'h000F);
        chk({clk_div1, pwr_down, low_pwr, amp_pwr_down} == 4'b0111, "R8 ctrl2 decode B",
            {28'h0, clk_div1, pwr_down, low_pwr, amp_pwr_down}, 32'h7);

        // R9/R10 good download, length 0 -> 8 coefficients
        write_reg(16'h0001, 16'h800D);
        chk(dl_busy == 1'b1, "R9 download active", {31'h0, dl_busy}, 32'h1);
        sum = '0;
        for (int i = 0; i < 8; i++) begin
            logic [15:0] w;
            w = 16'h1000 + 16'(i) * 16'h0101;
            sum = sum + w;
            exp_coef_q.push_back({8'(i), w});
            beat(w);
        end
        chk(dl_busy == 1'b1 && !coef_commit, "R9 waiting for checksum", {30'h0, dl_busy, coef_commit}, 32'h2);
        beat(sum);
        chk(coef_commit == 1'b1, "R10 commit on match", {31'h0, coef_commit}, 32'h1);
        chk(dl_busy == 1'b0, "R9 download ends", {31'h0, dl_busy}, 32'h0);
        @(negedge clk);
        chk(coef_commit == 1'b0, "R10 commit one cycle", {31'h0, coef_commit}, 32'h0);
        write_reg(16'h0001, 16'h080D);
        do_read(16'h0008, "R10 filter loaded flag");

        // R10 bad checksum, length 1 -> 16 coefficients
        write_reg(16'h0001, 16'h802D);
        sum = '0;
        for (int i = 0; i < 16; i++) begin
            logic [15:0] w;
            w = 16'hF00F ^ (16'(i) * 16'd7);
            sum = sum + w;
            exp_coef_q.push_back({8'(i), w});
            beat(w);
        end
        beat(sum + 16'd1);
        chk(coef_commit == 1'b0 && dl_busy == 1'b0, "R10 no commit on mismatch",
            {30'h0, coef_commit, dl_busy}, 32'h0);
        write_reg(16'h0001, 16'h080D);
        do_read(16'h000C, "R10 checksum error flag");
        chk(coef_seen == 24 && exp_coef_q.size() == 0, "R9 coefficient count", coef_seen, 32'd24);

        // R1 channel back to address words after download
        write_reg(16'h0003, 16'h5555);
        chk(gain_val == 16'h5555, "R1 write after download", {16'h0, gain_val}, 32'h5555);

        repeat (3) @(negedge clk);
        chk(exp_rd_q.size() == 0, "R12 all reads answered", exp_rd_q.size(), 32'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule